// File: doc/BRIEF.md
# Unaligned Sync Detector and Word Aligner

The block sits on a 32-bit parallel input that carries a fresh word on every clock (50 MHz nominal). The stream is read most significant bit first inside each word, and words follow each other in time order. Somewhere in that stream a 32-bit sync marker appears: a single zero followed by thirty-one ones. The zero may land on any bit of the bus, so the marker normally straddles two consecutive words.

Every cycle, the block joins the previous word and the current word into one window and tests all thirty-two possible marker positions against it in parallel. No serial shift register is used. When a position matches, the block records that bit offset and switches to a locked mode. From then on it presents one realigned 32-bit word per clock, each tagged valid, for a downstream consumer such as a decompressor. The first output word starts at the bit right after the marker. A resync input or a synchronous reset drops the lock and starts the search again.

Top module: `sync_aligner`

## Requirements
- R1: While `rst_i` is high, `word_valid_o` is low at every rising edge. After reset it stays low until a sync marker has been found.
- R2: The marker is 0x7FFFFFFF read bit 31 first. Its leading zero may sit on any of the 32 bit positions (k = 31 down to 0) of an input word. All 32 positions are tested in the same clock, with no serial shifting.
- R3: In lock, `word_o` holds the next 32 stream bits after the marker, with the earliest bit in bit 31. Consecutive valid outputs carry consecutive, non-overlapping 32-bit pieces of the stream.
- R4: The first valid word appears exactly two rising edges after the input word that holds the first message bit is presented: the edge that samples that word, then one more.
- R5: Once locked, `word_valid_o` stays high on every clock and the bit offset does not change. Further markers in the message data have no effect.
- R6: A high `resync_i` at a rising edge makes `word_valid_o` low from that edge on. The search then restarts on the input that follows, and a new offset can be locked.
- R7: If `resync_i` is high in the same cycle that a marker would be detected, the resync wins and no lock is taken.
- R8: The first word after reset is never tested together with the cleared history. A marker can only be found once at least one real word has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one input word per rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| resync_i | input | 1 | Drops the lock and restarts the marker search |
| word_i | input | 32 | Incoming stream word, earliest bit in bit 31 |
| word_o | output | 32 | Realigned message word |
| word_valid_o | output | 1 | High when `word_o` carries a message word |

## Verification
The hardest case to reach from the ports is a resync that arrives in exactly the cycle in which a marker completes. The bench reaches it by placing the marker's zero at a chosen bit of a chosen word, so it knows in advance which input word triggers detection, and it raises `resync_i` on that word. The cold-start case is reached the same way. Just after reset, the bench sends an all-ones word whose bits would form a marker together with a cleared history register. The marker is also swept across all 32 offsets, each with its own latency check.

// File: rtl/sync_aligner_pkg.sv
package sync_aligner_pkg;

   // Lock state of the aligner
   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_LOCKED = 1'b1
   } align_state_e;

   // Variants of the slice selector
   localparam int SEL_STYLE_MUX   = 0;  // flat N:1 multiplexer over all slices
   localparam int SEL_STYLE_SHIFT = 1;  // logarithmic right shifter

endpackage

// File: rtl/sa_window_matcher.sv
// Compares every WORD_W-bit slice of the search window with the marker.
// Slice o covers win_i[o+WORD_W-1 : o]; o = WORD_W-1 is the previous word.
module sa_window_matcher #(
   parameter int WORD_W = 32,
   parameter logic [WORD_W-1:0] SYNC_WORD = {1'b0, {(WORD_W-1){1'b1}}},
   localparam int WIN_W = 2*WORD_W - 1
) (
   input  logic [WIN_W-1:0]  win_i,
   output logic [WORD_W-1:0] hit_o
);

   if (WORD_W < 4) begin : g_bad_width
      $error("sa_window_matcher: WORD_W must be at least 4");
   end

   for (genvar o = 0; o < WORD_W; o++) begin : g_cmp
      assign hit_o[o] = (win_i[o+WORD_W-1 -: WORD_W] == SYNC_WORD);
   end

endmodule

// File: rtl/sa_lowest_hit.sv
// Priority encoder: reports the lowest set position of hit_i.
module sa_lowest_hit #(
   parameter int N = 32,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     hit_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   if (N < 2) begin : g_bad_n
      $error("sa_lowest_hit: N must be at least 2");
   end

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (hit_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

   // Contract: the reported index is a set bit and no lower bit is set
   always_comb begin
      if (found_o) begin
         assert_lowest_is_set_R2: assert (hit_i[idx_o]);
      end
   end

endmodule

// File: rtl/sa_slice_select.sv
// Extracts the WORD_W-bit slice of the window that starts at offset off_i.
module sa_slice_select #(
   parameter int WORD_W    = 32,
   parameter int SEL_STYLE = sync_aligner_pkg::SEL_STYLE_SHIFT,
   localparam int WIN_W = 2*WORD_W - 1,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic [WIN_W-1:0]  win_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [WORD_W-1:0] slice_o
);

   if ((WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
      $error("sa_slice_select: WORD_W must be a power of two");
   end

   if (SEL_STYLE == sync_aligner_pkg::SEL_STYLE_MUX) begin : g_mux
      logic [WORD_W-1:0] cand [WORD_W];
      for (genvar o = 0; o < WORD_W; o++) begin : g_cand
         assign cand[o] = win_i[o+WORD_W-1 -: WORD_W];
      end
      assign slice_o = cand[off_i];
   end else if (SEL_STYLE == sync_aligner_pkg::SEL_STYLE_SHIFT) begin : g_shift
      logic [WIN_W-1:0] stg [OFF_W+1];
      assign stg[0] = win_i;
      for (genvar b = 0; b < OFF_W; b++) begin : g_stage
         assign stg[b+1] = off_i[b] ? (stg[b] >> (1 << b)) : stg[b];
      end
      assign slice_o = WORD_W'(stg[OFF_W]);
   end else begin : g_bad_style
      $error("sa_slice_select: unknown SEL_STYLE");
   end

endmodule

// File: rtl/sync_aligner.sv
// Unaligned sync detector and word aligner.
module sync_aligner #(
   parameter int WORD_W    = 32,
   parameter logic [WORD_W-1:0] SYNC_WORD = {1'b0, {(WORD_W-1){1'b1}}},
   parameter int SEL_STYLE = sync_aligner_pkg::SEL_STYLE_SHIFT
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              resync_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o
);

   import sync_aligner_pkg::*;

   localparam int OFF_W = $clog2(WORD_W);
   localparam int WIN_W = 2*WORD_W - 1;

   if (WORD_W < 4 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
      $error("sync_aligner: WORD_W must be a power of two, at least 4");
   end
   if (SYNC_WORD[WORD_W-1] != 1'b0) begin : g_bad_sync
      $error("sync_aligner: marker must start with its zero bit");
   end

   // ---------------------------------------------------------------
   // History and search window
   // ---------------------------------------------------------------
   logic [WORD_W-1:0] prev_q;
   logic              primed_q;      // prev_q holds a real word
   align_state_e      state_q;
   logic [OFF_W-1:0]  off_q;
   logic [WIN_W-1:0]  win;

   // Bit 0 of the current word is never the top of a marker slice here
   assign win = {prev_q, word_i[WORD_W-1:1]};

   // ---------------------------------------------------------------
   // Parallel offset search
   // ---------------------------------------------------------------
   logic [WORD_W-1:0] hit_raw;
   logic [WORD_W-1:0] hit_use;
   logic              hit_found;
   logic [OFF_W-1:0]  hit_idx;

   sa_window_matcher #(
      .WORD_W    (WORD_W),
      .SYNC_WORD (SYNC_WORD)
   ) u_match (
      .win_i (win),
      .hit_o (hit_raw)
   );

   assign hit_use = primed_q ? hit_raw : '0;

   sa_lowest_hit #(
      .N (WORD_W)
   ) u_prio (
      .hit_i   (hit_use),
      .found_o (hit_found),
      .idx_o   (hit_idx)
   );

   // ---------------------------------------------------------------
   // Realignment
   // ---------------------------------------------------------------
   logic [WORD_W-1:0] slice;

   sa_slice_select #(
      .WORD_W    (WORD_W),
      .SEL_STYLE (SEL_STYLE)
   ) u_sel (
      .win_i   (win),
      .off_i   (off_q),
      .slice_o (slice)
   );

   // ---------------------------------------------------------------
   // State and output registers
   // ---------------------------------------------------------------
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q       <= '0;
         primed_q     <= 1'b0;
         state_q      <= ST_SEARCH;
         off_q        <= '0;
         word_o       <= '0;
         word_valid_o <= 1'b0;
      end else begin
         prev_q   <= word_i;
         primed_q <= 1'b1;
         if (resync_i) begin
            state_q      <= ST_SEARCH;
            word_valid_o <= 1'b0;
         end else begin
            unique case (state_q)
               ST_SEARCH: begin
                  word_valid_o <= 1'b0;
                  if (hit_found) begin
                     state_q <= ST_LOCKED;
                     off_q   <= hit_idx;
                  end
               end
               ST_LOCKED: begin
                  word_valid_o <= 1'b1;
                  word_o       <= slice;
               end
               default: begin
                  state_q      <= ST_SEARCH;
                  word_valid_o <= 1'b0;
               end
            endcase
         end
      end
   end

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   assert_resync_drops_valid_R6: assert property (
      @(posedge clk_i) disable iff (rst_i)
      resync_i |=> !word_valid_o);

   assert_resync_wins_R7: assert property (
      @(posedge clk_i) disable iff (rst_i)
      resync_i |=> (state_q == ST_SEARCH));

   assert_lock_keeps_streaming_R5: assert property (
      @(posedge clk_i) disable iff (rst_i)
      (word_valid_o && !resync_i) |=> word_valid_o);

   assert_offset_held_R5: assert property (
      @(posedge clk_i) disable iff (rst_i)
      (state_q == ST_LOCKED && !resync_i) |=> (state_q == ST_LOCKED && $stable(off_q)));

   assert_no_cold_match_R8: assert property (
      @(posedge clk_i) disable iff (rst_i)
      !primed_q |=> (state_q == ST_SEARCH));

   assert_valid_follows_lock_R4: assert property (
      @(posedge clk_i) disable iff (rst_i)
      $rose(word_valid_o) |-> ($past(state_q) == ST_LOCKED && $past(state_q, 2) == ST_SEARCH));

endmodule

// File: tb/sync_aligner_tb_top.sv
module sync_aligner_tb_top;

   localparam int CLK_PERIOD = 20;
   localparam int W = 32;
   localparam logic [W-1:0] SYNC = 32'h7FFF_FFFF;

   logic         clk = 1'b0;
   logic         rst;
   logic         resync;
   logic [W-1:0] din;
   logic [W-1:0] dout;
   logic         dout_valid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model state
   bit           sb[$];
   int           nwords;
   bit           m_locked;
   int           m_next;
   int           msg_word;
   bit           exp_valid;
   logic [W-1:0] exp_data;
   bit           dut_valid_prev;
   string        vtag;
   logic [W-1:0] wq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_aligner dut_i (
      .clk_i        (clk),
      .rst_i        (rst),
      .resync_i     (resync),
      .word_i       (din),
      .word_o       (dout),
      .word_valid_o (dout_valid)
   );

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Behavioural model: the stream as a bit list, searched by position
   task automatic model_step(logic [W-1:0] w, bit r);
      bit was_locked;
      bit ok;
      was_locked = m_locked;
      for (int i = W-1; i >= 0; i--) sb.push_back(w[i]);
      nwords++;
      exp_valid = was_locked && !r;
      if (exp_valid) begin
         for (int i = 0; i < W; i++) exp_data[W-1-i] = sb[m_next+i];
         m_next += W;
      end
      if (r) begin
         m_locked = 1'b0;
      end else if (!was_locked && nwords >= 2) begin
         for (int s = W*(nwords-1)-1; s >= W*(nwords-2); s--) begin
            if (!m_locked) begin
               ok = 1'b1;
               for (int i = 0; i < W; i++) if (sb[s+i] != SYNC[W-1-i]) ok = 1'b0;
               if (ok) begin
                  m_locked = 1'b1;
                  m_next   = s + W;
                  msg_word = (s + W) / W;
               end
            end
         end
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic step(logic [W-1:0] w, bit r);
      din    = w;
      resync = r;
      model_step(w, r);
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(vtag, {31'b0, dout_valid}, {31'b0, exp_valid});
      if (exp_valid && dout_valid) check("R3 data", dout, exp_data);
      if (dout_valid && !dut_valid_prev)
         check("R4 latency", 32'(nwords - 1 - msg_word), 32'd1);
      dut_valid_prev = dout_valid;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst    = 1'b1;
      resync = 1'b0;
      din    = '0;
      repeat (2) @(posedge clk);
      #(CLK_PERIOD/4);
      check("R1 reset", {31'b0, dout_valid}, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      sb.delete();
      nwords = 0; m_locked = 1'b0; m_next = 0; msg_word = -1;
      dut_valid_prev = 1'b0;
   endtask

   // Marker zero at bit k of word 2, then nmsg message words, then padding
   task automatic build_stream(int k, int nmsg);
      bit b[$];
      logic [W-1:0] w;
      wq.delete();
      for (int i = 0; i < 2*W + (W-1-k); i++) b.push_back(1'($urandom_range(0, 1)));
      for (int i = W-1; i >= 0; i--) b.push_back(SYNC[i]);
      for (int i = 0; i < nmsg*W; i++) b.push_back(1'($urandom_range(0, 1)));
      while ((b.size() % W) != 0) b.push_back(1'($urandom_range(0, 1)));
      for (int i = 0; i < 2*W; i++) b.push_back(1'($urandom_range(0, 1)));
      for (int j = 0; j < b.size()/W; j++) begin
         for (int i = 0; i < W; i++) w[W-1-i] = b[j*W+i];
         wq.push_back(w);
      end
   endtask

   task automatic run_stream(int rs_idx);
      for (int i = 0; i < wq.size(); i++) step(wq[i], i == rs_idx);
   endtask

   initial begin
      rst = 1'b1; resync = 1'b0; din = '0;

      // R1: quiet after reset while no marker is present
      do_reset();
      vtag = "R1 idle";
      repeat (4) step(32'h0000_0000, 1'b0);

      // R2/R3/R4: marker at every offset
      for (int k = 0; k < W; k++) begin
         do_reset();
         vtag = "R2 sweep";
         build_stream(k, 3);
         run_stream(-1);
         check("R2 locked", {31'b0, dout_valid}, 32'd1);
      end

      // R5: a second marker inside the message is ignored
      do_reset();
      vtag = "R5 hold";
      build_stream(7, 4);
      wq[4] = SYNC;
      wq[5] = 32'h8000_FFFF;
      run_stream(-1);
      check("R5 still valid", {31'b0, dout_valid}, 32'd1);

      // R6: resync, then relock at a new offset
      do_reset();
      vtag = "R6 resync";
      build_stream(10, 3);
      run_stream(-1);
      step(32'h1234_5678, 1'b1);
      check("R6 dropped", {31'b0, dout_valid}, 32'd0);
      build_stream(21, 2);
      run_stream(-1);
      check("R6 relocked", {31'b0, dout_valid}, 32'd1);

      // R7: resync in the detection cycle (marker in word 2, detected on word 3)
      do_reset();
      vtag = "R7 collide";
      build_stream(13, 3);
      run_stream(3);
      check("R7 no lock", {31'b0, dout_valid}, 32'd0);

      // R8: first word after reset against cleared history
      do_reset();
      vtag = "R8 cold";
      step(32'hFFFF_FFFF, 1'b0);
      repeat (3) step(32'h0000_0000, 1'b0);
      check("R8 no lock", {31'b0, dout_valid}, 32'd0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule